// File: doc/BRIEF.md
# Counter-Compare PWM Modulator

This block turns a 5-bit sample word into a single-bit pulse-width-modulated stream. A sawtooth counter runs from 0 to 31 and wraps. It advances once per modulator tick, and the output bit is high while the sample in force exceeds the counter. The carrier period is therefore 32 modulator ticks, and the share of high time is the sample divided by 32. An external low-pass filter rebuilds the analog level from this stream.

The sample comes from one of two sources:
- **Static mode:** a word held on an input port.
- **Sine mode:** a built-in 100-point sine table. Its read index steps on a separate sample-rate tick, so the modulating tone is independent of the carrier.

Two programmable integer dividers of the system clock produce the modulator tick and the sample-rate tick. A new sample takes effect only at the start of a carrier period, so every period is built from one constant value.

Top module: `pwm_modulator`

## Requirements
- R1: While reset is asserted, and for the whole first carrier period after it is released, `pwm_out` is 0. The counter and the sine index both start at 0.
- R2: The sawtooth counter is 5 bits wide and wraps from 31 to 0. One carrier period is 32 modulator ticks, which is 32·(`mod_div`+1) system clocks.
- R3: On each modulator tick, `pwm_out` is registered as 1 exactly when the sample in force is strictly greater than the new counter value. A constant sample S gives S high ticks in every 32.
- R4: The sample in force is loaded only on the tick where the counter wraps to 0. Changes of `static_sample`, `src_sel` or the sine index during a period have no effect on that period.
- R5: With `src_sel` = 0 (static mode), the value loaded at a wrap is `static_sample`.
- R6: With `src_sel` = 1 (sine mode), the value loaded at a wrap is table entry i, where i is the current index. Entry i equals 16 + trunc(15·sin(2πi/100)) for i = 0..99, so every entry lies in 1..31. The index advances by one per sample tick and goes from 99 back to 0.
- R7: A modulator tick occurs once in every `mod_div`+1 system clocks. A sample tick occurs once in every `smp_div`+1 system clocks. A divisor of 0 gives a tick on every clock.
- R8: `pwm_out` changes only in the clock that follows a modulator tick.
- R9: A sample of 0 keeps `pwm_out` low for the whole period. A sample of 31 gives 31 high ticks in each 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_div | input | 16 | Modulator tick divisor (period = value+1 clocks) |
| smp_div | input | 16 | Sample tick divisor (period = value+1 clocks) |
| src_sel | input | 1 | Sample source: 0 static, 1 sine table |
| static_sample | input | 5 | Sample word used in static mode |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench goes after the extreme samples:
- A comparison written as greater-or-equal would leave a sample of 0 high for one tick per period.
- The same error would drive a sample of 31 high for the whole period.

It also rewrites the static sample mid-period and then restores it. A design that loaded the sample on every tick, instead of only at the wrap, would stretch that period's high time. Sine mode is run with the index stepping both faster and slower than the carrier, and long enough to pass index 99. An index that skipped its wrap, or a table entry that was off by one, shows up as a wrong duty count against the model. A divisor that was off by one shows up in the measured carrier period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int SMP_W    = 5;
  localparam int SINE_N   = 100;
  localparam int SINE_Q   = SINE_N / 4;
  localparam int SINE_MID = 16;
  localparam int IDX_W    = $clog2(SINE_N);

  typedef enum logic {
    SRC_STATIC = 1'b0,
    SRC_SINE   = 1'b1
  } src_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: after a tick the next one is at least div+1 clocks away
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/pwm_sample_src.sv
module pwm_sample_src
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_tick,
  input  logic             src_sel,
  input  logic [SMP_W-1:0] static_sample,
  output logic [SMP_W-1:0] src_sample
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SMP_W-1:0] sine_word;

  // 15*sin(2*pi*k/100) truncated, first quarter wave k = 0..25
  function automatic int quarter(input int k);
    case (k)
      0, 1:                 return 0;
      2:                    return 1;
      3:                    return 2;
      4:                    return 3;
      5:                    return 4;
      6:                    return 5;
      7:                    return 6;
      8:                    return 7;
      9, 10:                return 8;
      11:                   return 9;
      12, 13:               return 10;
      14:                   return 11;
      15, 16:               return 12;
      17, 18, 19:           return 13;
      20, 21, 22, 23, 24:   return 14;
      default:              return 15;
    endcase
  endfunction

  function automatic logic [SMP_W-1:0] sine_val(input logic [IDX_W-1:0] ix);
    int i, q;
    i = int'(ix);
    if (i <= SINE_Q)            q =  quarter(i);
    else if (i < 2*SINE_Q)      q =  quarter(2*SINE_Q - i);
    else if (i <= 3*SINE_Q)     q = -quarter(i - 2*SINE_Q);
    else                        q = -quarter(SINE_N - i);
    return SMP_W'(SINE_MID + q);
  endfunction

  always_comb begin
    idx_d = idx_q;
    if (smp_tick)
      idx_d = (idx_q == IDX_W'(SINE_N - 1)) ? '0 : idx_q + IDX_W'(1);
    sine_word  = sine_val(idx_q);
    src_sample = (src_t'(src_sel) == SRC_SINE) ? sine_word : static_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R6: index never leaves the table, and moves only on a sample tick
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(SINE_N - 1));
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_tick |=> $stable(idx_q));
  p_sine_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sine_word >= SMP_W'(1)) && (sine_word <= SMP_W'(31)));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_tick,
  input  logic [SMP_W-1:0] src_sample,
  output logic             pwm_out
);
  localparam logic [SMP_W-1:0] CNT_MAX = {SMP_W{1'b1}};

  logic [SMP_W-1:0] cnt_q, cnt_d, smp_q, smp_d;
  logic             out_q, out_d, wrap;

  always_comb begin
    wrap  = mod_tick && (cnt_q == CNT_MAX);
    cnt_d = cnt_q;
    smp_d = smp_q;
    out_d = out_q;
    if (mod_tick) begin
      cnt_d = cnt_q + SMP_W'(1);
      if (wrap) smp_d = src_sample;
      out_d = (smp_d > cnt_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
      out_q <= out_d;
    end
  end

  assign pwm_out = out_q;

  // R2: counter wraps to zero after its maximum
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_tick && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  // R4: sample in force is held except on the wrapping tick
  p_sample_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_tick && cnt_q == CNT_MAX) |=> $stable(smp_q));
  // R8: output only moves after a modulator tick
  p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_tick |=> $stable(pwm_out));
  // R9: a zero sample never drives the output high
  p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q == '0) |-> !pwm_out);
endmodule

// File: rtl/pwm_modulator.sv
module pwm_modulator
  import pwm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mod_div,
  input  logic [DIV_W-1:0] smp_div,
  input  logic             src_sel,
  input  logic [SMP_W-1:0] static_sample,
  output logic             pwm_out
);
  logic             mod_tick, smp_tick;
  logic [SMP_W-1:0] src_sample;

  pwm_tick_div #(.DIV_W(DIV_W)) u_mod_div (
    .clk(clk), .rst_n(rst_n), .div(mod_div), .tick(mod_tick));

  pwm_tick_div #(.DIV_W(DIV_W)) u_smp_div (
    .clk(clk), .rst_n(rst_n), .div(smp_div), .tick(smp_tick));

  pwm_sample_src u_src (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .src_sel(src_sel),
    .static_sample(static_sample), .src_sample(src_sample));

  pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick),
    .src_sample(src_sample), .pwm_out(pwm_out));
endmodule

// File: tb/pwm_modulator_test.sv
`timescale 1ns/1ps
module pwm_modulator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mod_div = '0;
  logic [15:0] smp_div = '0;
  logic        src_sel = 1'b0;
  logic [4:0]  static_sample = '0;
  logic        pwm_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_modulator uut (
    .clk(clk), .rst_n(rst_n), .mod_div(mod_div), .smp_div(smp_div),
    .src_sel(src_sel), .static_sample(static_sample), .pwm_out(pwm_out));

  function automatic int sine_ref(int i);
    real v;
    v = 15.0 * $sin(2.0 * 3.141592653589793 * i / 100.0);
    return 16 + $rtoi(v);
  endfunction

  // behavioural reference
  int m_mdc, m_sdc, m_cnt, m_smp, m_idx;
  bit m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mdc = 0; m_sdc = 0; m_cnt = 0; m_smp = 0; m_idx = 0; m_out = 0;
    end else begin
      bit mt, st;
      int src;
      mt  = (m_mdc >= int'(mod_div));
      st  = (m_sdc >= int'(smp_div));
      src = src_sel ? sine_ref(m_idx) : int'(static_sample);
      if (mt) begin
        if (m_cnt == 31) begin m_cnt = 0; m_smp = src; end
        else m_cnt = m_cnt + 1;
        m_out = (m_smp > m_cnt);
      end
      if (st) m_idx = (m_idx == 99) ? 0 : m_idx + 1;
      m_mdc = mt ? 0 : m_mdc + 1;
      m_sdc = st ? 0 : m_sdc + 1;
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (pwm_out !== m_out) begin
        fails++;
        $display("FAIL %s R8 cycle compare: pwm_out=%0b expected %0b",
                 src_sel ? "R6" : "R5/R3/R4", pwm_out, m_out);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic highs(int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++; $display("FAIL R1 in reset: got %0b expected 0", pwm_out);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_rise();
    bit prev;
    prev = pwm_out;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      prev = pwm_out;
    end
  endtask

  initial begin
    int h, t;
    // R1
    static_sample = 5'd20;
    do_reset();
    highs(31, h); check("R1 first period low", h, 0);
    // R3 duty 7/32
    static_sample = 5'd7;
    repeat (80) @(negedge clk);
    highs(32, h); check("R3 sample 7", h, 7);
    // R9 extremes
    static_sample = 5'd0;
    repeat (80) @(negedge clk);
    highs(64, h); check("R9 sample 0", h, 0);
    static_sample = 5'd31;
    repeat (80) @(negedge clk);
    highs(32, h); check("R9 sample 31", h, 31);
    // R3 strict compare at 1
    static_sample = 5'd1;
    repeat (80) @(negedge clk);
    highs(32, h); check("R3 sample 1", h, 1);
    // R4 mid-period change ignored
    static_sample = 5'd5;
    repeat (80) @(negedge clk);
    wait_rise();
    h = 1;
    for (int k = 0; k < 31; k++) begin
      if (k == 9)  static_sample = 5'd25;
      if (k == 19) static_sample = 5'd5;
      @(negedge clk);
      if (pwm_out) h++;
    end
    check("R4 mid-period change", h, 5);
    // R2 R7 carrier period with mod_div=3
    mod_div = 16'd3; static_sample = 5'd16;
    repeat (300) @(negedge clk);
    wait_rise();
    t = 0;
    while (pwm_out) begin @(negedge clk); t++; end
    check("R7 high time 16x4", t, 64);
    while (!pwm_out) begin @(negedge clk); t++; end
    check("R2 carrier period 32x4", t, 128);
    // R5 static source with slower modulator
    static_sample = 5'd10;
    repeat (300) @(negedge clk);
    highs(128, h); check("R5 static 10 at div 3", h, 40);
    // R6 entry 0 with index frozen
    mod_div = '0; smp_div = 16'hFFFF; src_sel = 1'b1;
    do_reset();
    repeat (40) @(negedge clk);
    highs(32, h); check("R6 entry 0", h, sine_ref(0));
    // R6 table stepped once per period, passing index 99
    smp_div = 16'd31;
    do_reset();
    repeat (3400) @(negedge clk);
    // R6 index stepped every clock and at a faster rate than carrier
    smp_div = 16'd0;
    repeat (4000) @(negedge clk);
    mod_div = 16'd1; smp_div = 16'd6;
    repeat (4000) @(negedge clk);
    // source switch mid-run
    src_sel = 1'b0; static_sample = 5'd3;
    repeat (500) @(negedge clk);
    check("R6 table entry 25", sine_ref(25), 31);
    check("R6 table entry 75", sine_ref(75), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule